// File: doc/BRIEF.md
# Digital Input Edge Interrupt Unit

The unit watches a bank of digital input lines, 24 by default, and raises one level interrupt when any selected line changes. Each line has its own rising-edge select bit and its own falling-edge select bit. Two global gates in the control register can turn off all rising or all falling detection at once. The first selected change sets an edge flag. If another selected change arrives while that flag is still set, it also sets an overflow flag, so software can tell that it missed events.

The inputs must already be synchronised or filtered. The unit compares each line with a registered copy of its value from the previous cycle. Software programs the unit and services it through byte-wide register writes and combinational reads. It clears the flags by writing one-bits to a command byte. The interrupt output is high while the master enable is set and an enabled flag is pending. Status bit 2 shows the same condition, so a handler can check it before it treats an event as valid.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset, all select masks, the control byte and both flags are zero, `irq` is low, and reading the status byte (0x14) returns 0x00.
- R2: The rising-select mask sits at byte addresses 0x18 (lines 7:0), 0x19 (lines 15:8) and 0x1A (lines 23:16). The falling-select mask sits at 0x20, 0x21 and 0x22 in the same order. The control byte is at 0x15. Each of these reads back the last value written.
- R3: Writing 0x00 to the control byte forces `irq` low and status bit 2 to zero. Both flags keep their values.
- R4: Control bit 3 gates all rising detection and control bit 4 gates all falling detection. When a gate bit is 0, a change in that direction sets no flag, even on a selected line.
- R5: `irq` equals control bit 2 AND ((edge flag AND control bit 0) OR (overflow flag AND control bit 1)). Status bit 2 reads the same value.
- R6: A 0-to-1 change on a line whose rising-select bit is set, or a 1-to-0 change on a line whose falling-select bit is set, sets status bit 0 at the clock edge that first samples the new level. Changes on lines that are not selected set no flag.
- R7: A selected change sets status bit 1 (overflow) when status bit 0 is already set at that clock edge. This holds even if a clear of the edge flag is written in the same cycle.
- R8: Writing to byte 0x07 with bit 3 set clears the edge flag, and with bit 2 set clears the overflow flag. One write can clear both. A selected change in the same cycle as a clear leaves the edge flag set.
- R9: A line held at a steady level after a change produces no further event. Detection responds to transitions only, not to levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 6 | Byte address for reads and writes |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Combinational read data for `addr` |
| lines | input | 24 | Digital inputs, already synchronised |
| irq | output | 1 | Level interrupt request |

## Verification
The failures that matter are a wrong flag or a stale previous-line copy. A missed edge shows at the status byte and at `irq` one clock after the transition, and the vector walk reads the status after every step. A stale previous-line copy shows as a repeated event on a steady line, which then sets overflow on the next step. A wrong clear priority shows up in the cycle right after a clear that collides with an event. Gating or enable errors show at `irq` as soon as the control byte changes, because the interrupt is decoded combinationally from the registered flags.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

    localparam int AW       = 6;
    localparam int NLINES   = 24;
    localparam int NBYTES   = (NLINES + 7) / 8;

    localparam logic [AW-1:0] A_CLEAR    = 6'h07;
    localparam logic [AW-1:0] A_STATUS   = 6'h14;
    localparam logic [AW-1:0] A_CTRL     = 6'h15;
    localparam logic [AW-1:0] A_RISE_SEL = 6'h18;
    localparam logic [AW-1:0] A_FALL_SEL = 6'h20;

    localparam int CLR_OVF_BIT  = 2;
    localparam int CLR_EDGE_BIT = 3;

    typedef struct packed {
        logic [2:0] spare;
        logic       fall_gate;
        logic       rise_gate;
        logic       master;
        logic       ovf_ie;
        logic       edge_ie;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] spare;
        logic       pending;
        logic       ovf;
        logic       edge_seen;
    } status_t;

    function automatic logic [AW-1:0] byte_addr(logic [AW-1:0] base, int idx);
        return base + AW'(idx);
    endfunction

endpackage

// File: rtl/eiu_edge_detect.sv
module eiu_edge_detect
    import edge_irq_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] rise_sel,
    input  logic [N-1:0] fall_sel,
    input  logic         rise_gate,
    input  logic         fall_gate,
    output logic         event_any
);

    logic [N-1:0] prev_q;
    logic [N-1:0] rose, fell;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lines;
    end

    always_comb begin
        rose      = lines & ~prev_q & rise_sel & {N{rise_gate}};
        fell      = ~lines & prev_q & fall_sel & {N{fall_gate}};
        event_any = |(rose | fell);
    end

    // R4: with both gates off no event may be reported
    a_r4_gates_block: assert property (@(posedge clk) disable iff (rst)
        (!rise_gate && !fall_gate) |-> !event_any);

    // R9: steady inputs over a cycle produce no event
    a_r9_steady_quiet: assert property (@(posedge clk) disable iff (rst)
        ($stable(lines) && !$past(rst)) |=> (!$changed(lines) |-> !event_any));

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import edge_irq_pkg::*;
#(
    parameter int N = NLINES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  status_t       status,
    output logic [N-1:0]  rise_sel,
    output logic [N-1:0]  fall_sel,
    output ctrl_t         ctrl,
    output logic          clr_edge,
    output logic          clr_ovf,
    output logic [7:0]    rdata
);

    localparam int NB = (N + 7) / 8;

    logic [NB*8-1:0] rise_q, fall_q;
    ctrl_t           ctrl_q;

    for (genvar b = 0; b < NB; b++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                rise_q[b*8 +: 8] <= '0;
                fall_q[b*8 +: 8] <= '0;
            end else if (wr_en) begin
                if (addr == byte_addr(A_RISE_SEL, b)) rise_q[b*8 +: 8] <= wdata;
                if (addr == byte_addr(A_FALL_SEL, b)) fall_q[b*8 +: 8] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                             ctrl_q <= '0;
        else if (wr_en && addr == A_CTRL)    ctrl_q <= ctrl_t'(wdata);
    end

    always_comb begin
        rise_sel = rise_q[N-1:0];
        fall_sel = fall_q[N-1:0];
        ctrl     = ctrl_q;
        clr_edge = wr_en && addr == A_CLEAR && wdata[CLR_EDGE_BIT];
        clr_ovf  = wr_en && addr == A_CLEAR && wdata[CLR_OVF_BIT];
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == A_STATUS) rdata = status;
        if (addr == A_CTRL)   rdata = ctrl_q;
        for (int b = 0; b < NB; b++) begin
            if (addr == byte_addr(A_RISE_SEL, b)) rdata = rise_q[b*8 +: 8];
            if (addr == byte_addr(A_FALL_SEL, b)) rdata = fall_q[b*8 +: 8];
        end
    end

    // R2: control byte changes only through a write to its address
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && addr == A_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/eiu_flags.sv
module eiu_flags
    import edge_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    event_any,
    input  logic    clr_edge,
    input  logic    clr_ovf,
    input  ctrl_t   ctrl,
    output status_t status,
    output logic    irq
);

    logic edge_q, ovf_q, pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            edge_q <= (edge_q && !clr_edge) || event_any;
            ovf_q  <= (ovf_q && !clr_ovf) || (event_any && edge_q);
        end
    end

    always_comb begin
        pend   = ctrl.master && ((edge_q && ctrl.edge_ie) || (ovf_q && ctrl.ovf_ie));
        irq    = pend;
        status = '{spare: '0, pending: pend, ovf: ovf_q, edge_seen: edge_q};
    end

    // R5: no request without the master enable
    a_r5_master_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl.master);

    // R6 / R8: an event always leaves the edge flag set, clear or not
    a_r6_event_sets: assert property (@(posedge clk) disable iff (rst)
        event_any |=> edge_q);

    // R7: overflow can only rise after the edge flag was already set
    a_r7_overflow_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(edge_q));

    // R8: a clear with no colliding event drops the edge flag
    a_r8_clear_edge: assert property (@(posedge clk) disable iff (rst)
        (clr_edge && !event_any) |=> !edge_q);

    // R8: overflow clear takes effect next cycle
    a_r8_clear_ovf: assert property (@(posedge clk) disable iff (rst)
        (clr_ovf && !(event_any && edge_q)) |=> !ovf_q);

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import edge_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NLINES-1:0] lines,
    output logic              irq
);

    logic [NLINES-1:0] rise_sel, fall_sel;
    ctrl_t             ctrl;
    status_t           status;
    logic              clr_edge, clr_ovf, event_any;

    eiu_regs #(.N(NLINES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .status(status), .rise_sel(rise_sel), .fall_sel(fall_sel),
        .ctrl(ctrl), .clr_edge(clr_edge), .clr_ovf(clr_ovf), .rdata(rdata)
    );

    eiu_edge_detect #(.N(NLINES)) u_detect (
        .clk(clk), .rst(rst), .lines(lines), .rise_sel(rise_sel),
        .fall_sel(fall_sel), .rise_gate(ctrl.rise_gate),
        .fall_gate(ctrl.fall_gate), .event_any(event_any)
    );

    eiu_flags u_flags (
        .clk(clk), .rst(rst), .event_any(event_any), .clr_edge(clr_edge),
        .clr_ovf(clr_ovf), .ctrl(ctrl), .status(status), .irq(irq)
    );

    // R3: a zero control byte means no request at all
    a_r3_zero_ctrl_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl == '0) |-> !irq);

endmodule

// File: tb/edge_irq_unit_test.sv
module edge_irq_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [23:0] lines = '0;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    edge_irq_unit uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lines(lines), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {lines, byte written to clear register (0 = none), expected status}
    localparam logic [39:0] VECS [12] = '{
        {24'h000001, 8'h00, 8'h05},  // R6 rising on line 0
        {24'h000001, 8'h08, 8'h00},  // R8 R9 steady line, edge cleared
        {24'h000003, 8'h00, 8'h00},  // R6 line 1 not selected
        {24'h000013, 8'h00, 8'h05},  // R6 line 4 rising
        {24'h000033, 8'h00, 8'h07},  // R7 second event -> overflow
        {24'h000033, 8'h0C, 8'h00},  // R8 both cleared in one write
        {24'h800033, 8'h00, 8'h00},  // R6 rising on line 23 not selected
        {24'h000033, 8'h00, 8'h05},  // R6 falling on line 23 selected
        {24'h000032, 8'h08, 8'h00},  // R6 falling line 0 not selected
        {24'h000033, 8'h08, 8'h05},  // R8 clear collides with event
        {24'h000073, 8'h08, 8'h07},  // R7 event while set, even with clear
        {24'h000073, 8'h0C, 8'h00}   // R8 clean slate
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic step(input logic [23:0] l, input logic [7:0] clr);
        @(negedge clk);
        lines = l;
        if (clr != 8'h00) begin
            wr_en = 1'b1; addr = 6'h07; wdata = clr;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(6'h14, v); check("R1 status", v, 8'h00);
        rd(6'h15, v); check("R1 ctrl", v, 8'h00);
        rd(6'h18, v); check("R1 rise sel", v, 8'h00);
        rd(6'h22, v); check("R1 fall sel", v, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 configuration and read-back
        wr(6'h18, 8'hF1);
        wr(6'h22, 8'h80);
        wr(6'h15, 8'h1F);
        rd(6'h18, v); check("R2 rise sel byte0", v, 8'hF1);
        rd(6'h19, v); check("R2 rise sel byte1", v, 8'h00);
        rd(6'h22, v); check("R2 fall sel byte2", v, 8'h80);
        rd(6'h15, v); check("R2 ctrl", v, 8'h1F);

        // vector walk
        for (int i = 0; i < 12; i++) begin
            step(VECS[i][39:16], VECS[i][15:8]);
            rd(6'h14, v);
            check($sformatf("R6/R7/R8 vector %0d", i), v, VECS[i][7:0]);
            check($sformatf("R5 irq vector %0d", i), {7'b0, irq}, {7'b0, VECS[i][2]});
        end

        // R4 rising gate off, falling gate on
        wr(6'h15, 8'h17);
        step(24'h000063, 8'h00);
        step(24'h000073, 8'h00);
        rd(6'h14, v); check("R4 rising gated", v, 8'h00);
        // R4 falling gate off, rising gate on
        wr(6'h15, 8'h0F);
        step(24'h800073, 8'h00);
        step(24'h000073, 8'h00);
        rd(6'h14, v); check("R4 falling gated", v, 8'h00);

        // R5 per-source enables
        wr(6'h15, 8'h1F);
        step(24'h000072, 8'h00);
        step(24'h000073, 8'h00);
        rd(6'h14, v); check("R5 edge pending", v, 8'h05);
        wr(6'h15, 8'h1E);
        rd(6'h14, v); check("R5 edge ie off status", v, 8'h01);
        check("R5 edge ie off irq", {7'b0, irq}, 8'h00);
        wr(6'h15, 8'h1B);
        step(24'h000072, 8'h00);
        step(24'h000073, 8'h00);
        rd(6'h14, v); check("R5 master off", v, 8'h03);
        check("R5 master off irq", {7'b0, irq}, 8'h00);
        wr(6'h15, 8'h1E);
        rd(6'h14, v); check("R5 overflow source", v, 8'h07);
        check("R5 overflow irq", {7'b0, irq}, 8'h01);

        // R3 zero control
        wr(6'h15, 8'h00);
        rd(6'h14, v); check("R3 flags kept", v, 8'h03);
        check("R3 irq low", {7'b0, irq}, 8'h00);
        step(24'h000073, 8'h0C);
        rd(6'h14, v); check("R8 final clear", v, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule